// File: doc/BRIEF.md
# ADC Conversion Controller

This block is the digital front of a 10-bit successive-approximation converter. Software programs it over a small 16-bit register bus. It holds the control word, two offset-trim values, the analog option bits and the last conversion result. When software sets the start bit, the controller runs a start/done handshake with the analog converter, which sits outside the block. It writes the returned sample into the result register. It then raises an interrupt status bit, which software clears by writing to a dedicated register.

The input-multiplexer code, the single-ended flag, mute, clock select and the LDO controls are driven straight out as plain bits. The trim value that reaches the converter is chosen from the input mode and the effective sign. In chop mode the controller issues two conversions, with the converter sign flipped for the second one. It inverts the second raw sample, and it stores the rounded mean of the two samples, so that the internal offset of the converter cancels.

Top module: `adc_conv_ctrl`

## Requirements
- R1: The registers sit at byte offsets 0x0 (control), 0x2 (analog options, bits 3:0), 0x4 (positive trim, bits 9:0), 0x6 (negative trim, bits 9:0), 0x8 (interrupt clear) and 0xA (result, bits 9:0). All of them are zero after reset. Unused bits read 0. Offsets 0x8, 0xC, 0xE and any odd address read 0, and writes to 0xC and 0xE have no effect.
- R2: The control bits are: 0 enable, 1 start/busy, 2 test (stored only), 3 clock select, 4 interrupt status (read-only), 5 interrupt mask, 9:6 input select, 10 sign, 11 single-ended, 12 mute, 13 chop, 14 LDO enable, 15 LDO force-zero. The bits for clock select, single-ended, mute, LDO enable, LDO force-zero and the analog options drive their output ports directly.
- R3: A write to 0x0 with bits 0 and 1 both set, made while no conversion is running, drives cnv_start_o high for exactly the one cycle that follows the write. Bit 1 then reads 1 until the conversion ends.
- R4: On the edge after cnv_done_i is seen during a non-chop conversion, three things happen together: bit 1 reads 0, bit 4 reads 1, and the result register holds the cnv_data_i value that came with the done.
- R5: Any write to 0x8 clears the interrupt status. If a conversion completes on the same edge, the status is set instead.
- R6: irq_o is high exactly when the interrupt status is 1 and the mask bit 5 is 1.
- R7: cnv_en_o follows enable. A start written with bit 0 clear is ignored. Clearing enable during a conversion aborts it: bit 1 returns to 0, no interrupt is raised and the result register is left unchanged.
- R8: A start written while a conversion is running is ignored. No extra cnv_start_o pulse is issued.
- R9: In single-ended mode, mux_sel_o equals the select field. In differential mode it is 0 when the select field is 0000, and 0001 for every other code.
- R10: cnv_sign_o is the sign bit, inverted during the second chop sample. offset_trim_o carries the negative trim when single-ended with cnv_sign_o = 1, and the positive trim otherwise.
- R11: In chop mode two start pulses are issued, and the interrupt is raised only after the second done. With samples a and b, the stored result is (a + (~b) + 1) >> 1, computed 11 bits wide and kept to 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Masked interrupt request |
| cnv_en_o | output | 1 | Converter enable, low holds it in reset |
| cnv_start_o | output | 1 | One-cycle conversion request |
| cnv_sign_o | output | 1 | Effective converter sign |
| cnv_done_i | input | 1 | Conversion finished, one-cycle pulse |
| cnv_data_i | input | 10 | Raw sample, valid with cnv_done_i |
| mux_sel_o | output | 4 | Input multiplexer code |
| single_ended_o | output | 1 | Single-ended mode |
| mute_o | output | 1 | Mid-scale sampling |
| clk_sel_o | output | 1 | Converter clock source select |
| ldo_en_o | output | 1 | Converter LDO enable |
| ldo_zero_o | output | 1 | Force LDO output to zero |
| offset_trim_o | output | 10 | Active offset trim |
| ana_cfg_o | output | 4 | Analog option bits |

## Verification
The bench goes after the edges of the start/busy handshake. A start written during a conversion must not issue a second request; a design that accepted it would show an extra cnv_start_o pulse. Clearing enable mid-conversion must drop busy and leave both the result and the interrupt untouched; a design that let the late done through would set a stale interrupt. A clear write is timed to land on the completion edge, where the interrupt must survive. Chop mode uses sample pairs chosen to need rounding, so a design that skipped the inversion, the rounding term or the second request would store a wrong mean or interrupt after the first sample.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 4;
  localparam int CFG_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_TRMP = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_TRMN = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_RES  = 4'hA;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_e;

  typedef struct packed {
    logic             ldo_zero;
    logic             ldo_en;
    logic             chop;
    logic             mute;
    logic             se;
    logic             sign;
    logic [SEL_W-1:0] sel;
    logic             mask;
    logic             clk_sel;
    logic             test;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/adc_bus_regs.sv
module adc_bus_regs import adc_ctrl_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output ctrl_t             ctrl_o,
  output logic              int_o,
  output logic [DATA_W-1:0] trmp_o,
  output logic [DATA_W-1:0] trmn_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              start_o,
  output logic              start_chop_o
);
  localparam int PAD_W = BUS_W - DATA_W;

  logic wr;
  assign wr           = sel_i & we_i;
  assign start_o      = wr && addr_i == OFF_CTRL && wdata_i[1] && wdata_i[0] && !busy_i;
  assign start_chop_o = wdata_i[13];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      int_o  <= 1'b0;
      trmp_o <= '0;
      trmn_o <= '0;
      cfg_o  <= '0;
    end else begin
      if (wr && addr_i == OFF_CTRL) begin
        ctrl_o.en       <= wdata_i[0];
        ctrl_o.test     <= wdata_i[2];
        ctrl_o.clk_sel  <= wdata_i[3];
        ctrl_o.mask     <= wdata_i[5];
        ctrl_o.sel      <= wdata_i[9:6];
        ctrl_o.sign     <= wdata_i[10];
        ctrl_o.se       <= wdata_i[11];
        ctrl_o.mute     <= wdata_i[12];
        ctrl_o.chop     <= wdata_i[13];
        ctrl_o.ldo_en   <= wdata_i[14];
        ctrl_o.ldo_zero <= wdata_i[15];
      end
      if (wr && addr_i == OFF_CFG)  cfg_o  <= wdata_i[CFG_W-1:0];
      if (wr && addr_i == OFF_TRMP) trmp_o <= wdata_i[DATA_W-1:0];
      if (wr && addr_i == OFF_TRMN) trmn_o <= wdata_i[DATA_W-1:0];
      // completion wins over a simultaneous clear
      if (done_i)                                int_o <= 1'b1;
      else if (wr && addr_i == OFF_CLR)          int_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: rdata_o = {ctrl_o.ldo_zero, ctrl_o.ldo_en, ctrl_o.chop, ctrl_o.mute,
                           ctrl_o.se, ctrl_o.sign, ctrl_o.sel, ctrl_o.mask, int_o,
                           ctrl_o.clk_sel, ctrl_o.test, busy_i, ctrl_o.en};
      OFF_CFG:  rdata_o = {{(BUS_W-CFG_W){1'b0}}, cfg_o};
      OFF_TRMP: rdata_o = {{PAD_W{1'b0}}, trmp_o};
      OFF_TRMN: rdata_o = {{PAD_W{1'b0}}, trmn_o};
      OFF_RES:  rdata_o = {{PAD_W{1'b0}}, result_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq import adc_ctrl_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sign_i,
  input  logic              start_i,
  input  logic              chop_i,
  input  logic              cnv_done_i,
  input  logic [DATA_W-1:0] cnv_data_i,
  output logic              cnv_start_o,
  output logic              sign_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  seq_state_e        state_q;
  logic              chop_q, phase_q;
  logic [DATA_W-1:0] first_q, inv, avg;
  logic [DATA_W:0]   sum;
  logic              need_second;

  assign inv         = ~cnv_data_i;
  assign sum         = {1'b0, first_q} + {1'b0, inv} + (DATA_W+1)'(1);
  assign avg         = sum[DATA_W:1];
  assign need_second = chop_q & ~phase_q;

  assign busy_o      = state_q != SEQ_IDLE;
  assign cnv_start_o = state_q == SEQ_REQ;
  assign sign_o      = sign_i ^ phase_q;
  assign done_o      = state_q == SEQ_WAIT && cnv_done_i && en_i && !need_second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      chop_q   <= 1'b0;
      phase_q  <= 1'b0;
      first_q  <= '0;
      result_o <= '0;
    end else if (state_q != SEQ_IDLE && !en_i) begin
      state_q <= SEQ_IDLE;  // abort, result untouched
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_REQ;
          chop_q  <= chop_i;
          phase_q <= 1'b0;
        end
        SEQ_REQ:  state_q <= SEQ_WAIT;
        SEQ_WAIT: if (cnv_done_i) begin
          if (need_second) begin
            first_q <= cnv_data_i;
            phase_q <= 1'b1;
            state_q <= SEQ_REQ;
          end else begin
            result_o <= chop_q ? avg : cnv_data_i;
            phase_q  <= 1'b0;
            state_q  <= SEQ_IDLE;
          end
        end
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_input_route.sv
module adc_input_route import adc_ctrl_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              se_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              eff_sign_i,
  input  logic [DATA_W-1:0] trmp_i,
  input  logic [DATA_W-1:0] trmn_i,
  output logic [SEL_W-1:0]  mux_sel_o,
  output logic [DATA_W-1:0] trim_o
);
  // differential: code 0 is pair 0/1, anything else pair 2/3
  assign mux_sel_o = se_i ? sel_i : {{(SEL_W-1){1'b0}}, |sel_i};
  assign trim_o    = (se_i && eff_sign_i) ? trmn_i : trmp_i;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl import adc_ctrl_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              cnv_en_o,
  output logic              cnv_start_o,
  output logic              cnv_sign_o,
  input  logic              cnv_done_i,
  input  logic [DATA_W-1:0] cnv_data_i,
  output logic [SEL_W-1:0]  mux_sel_o,
  output logic              single_ended_o,
  output logic              mute_o,
  output logic              clk_sel_o,
  output logic              ldo_en_o,
  output logic              ldo_zero_o,
  output logic [DATA_W-1:0] offset_trim_o,
  output logic [CFG_W-1:0]  ana_cfg_o
);
  ctrl_t             ctrl;
  logic              int_st, busy, done, start_req, start_chop;
  logic [DATA_W-1:0] result, trmp, trmn;

  adc_bus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i(busy), .done_i(done), .result_i(result),
    .ctrl_o(ctrl), .int_o(int_st), .trmp_o(trmp), .trmn_o(trmn),
    .cfg_o(ana_cfg_o), .start_o(start_req), .start_chop_o(start_chop)
  );

  adc_conv_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .sign_i(ctrl.sign), .start_i(start_req), .chop_i(start_chop),
    .cnv_done_i, .cnv_data_i, .cnv_start_o, .sign_o(cnv_sign_o),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  adc_input_route #(.DATA_W(DATA_W)) u_route (
    .se_i(ctrl.se), .sel_i(ctrl.sel), .eff_sign_i(cnv_sign_o),
    .trmp_i(trmp), .trmn_i(trmn), .mux_sel_o, .trim_o(offset_trim_o)
  );

  assign irq_o          = int_st & ctrl.mask;
  assign cnv_en_o       = ctrl.en;
  assign single_ended_o = ctrl.se;
  assign mute_o         = ctrl.mute;
  assign clk_sel_o      = ctrl.clk_sel;
  assign ldo_en_o       = ctrl.ldo_en;
  assign ldo_zero_o     = ctrl.ldo_zero;
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk import adc_ctrl_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              cnv_done_i,
  input logic              cnv_start_o,
  input logic              cnv_en_o,
  input logic              single_ended_o,
  input logic [SEL_W-1:0]  mux_sel_o,
  input logic              int_st,
  input logic              busy
);
  logic clr_wr, ctrl_wr;
  assign clr_wr  = bus_sel_i && bus_we_i && bus_addr_i == OFF_CLR;
  assign ctrl_wr = bus_sel_i && bus_we_i && bus_addr_i == OFF_CTRL;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_start_o |=> !cnv_start_o);

  // R7
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_start_o |-> cnv_en_o);

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnv_en_o && !ctrl_wr) |=> !busy);

  // R4
  int_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_st) |-> $past(cnv_done_i));

  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !cnv_done_i) |=> !int_st);

  // R9
  diff_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_ended_o |-> mux_sel_o <= SEL_W'(1));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk u_chk (
  .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .cnv_done_i,
  .cnv_start_o, .cnv_en_o, .single_ended_o, .mux_sel_o,
  .int_st(int_st), .busy(busy)
);

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o, cnv_en_o, cnv_start_o, cnv_sign_o;
  logic        cnv_done_i = 1'b0;
  logic [9:0]  cnv_data_i = '0;
  logic [3:0]  mux_sel_o, ana_cfg_o;
  logic        single_ended_o, mute_o, clk_sel_o, ldo_en_o, ldo_zero_o;
  logic [9:0]  offset_trim_o;

  always #2 clk_i = ~clk_i;

  adc_conv_ctrl dut_i (.*);

  int checks = 0, fails = 0, pulses = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // converter stub: done LAT cycles after a request
  logic [9:0] samp_q[$];
  int lat = 5, cnt = 0;
  always @(posedge clk_i) begin
    cnv_done_i <= 1'b0;
    if (rst_ni) begin
      if (cnv_start_o) begin cnt = lat; pulses++; end
      else if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          cnv_done_i <= 1'b1;
          cnv_data_i <= (samp_q.size() > 0) ? samp_q.pop_front() : 10'h0;
        end
      end
    end
  end

  // reference model
  logic [15:0] m_ctrl;  // bits 1 and 4 kept 0, held separately
  logic [3:0]  m_cfg;
  logic [9:0]  m_trmp, m_trmn, m_res, m_first;
  bit          m_busy, m_req, m_int, m_chop;
  int          m_stage;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_cfg = 0; m_trmp = 0; m_trmn = 0; m_res = 0; m_first = 0;
      m_busy = 0; m_req = 0; m_int = 0; m_chop = 0; m_stage = 0;
    end else begin
      bit busy_old, set_int, clr;
      logic [9:0] inv;
      logic [10:0] s;
      busy_old = m_busy; set_int = 0; clr = 0;
      inv = ~cnv_data_i;
      if (m_busy) begin
        if (!m_ctrl[0]) begin m_busy = 0; m_req = 0; m_stage = 0; end
        else if (m_req) m_req = 0;
        else if (cnv_done_i) begin
          if (m_chop && m_stage == 1) begin m_first = cnv_data_i; m_stage = 2; m_req = 1; end
          else begin
            s = {1'b0, m_first} + {1'b0, inv} + 11'd1;
            m_res = m_chop ? s[10:1] : cnv_data_i;
            m_busy = 0; m_stage = 0; set_int = 1;
          end
        end
      end
      if (bus_sel_i && bus_we_i) begin
        case (bus_addr_i)
          4'h0: begin
            if (!busy_old && bus_wdata_i[0] && bus_wdata_i[1]) begin
              m_busy = 1; m_req = 1; m_stage = 1; m_chop = bus_wdata_i[13];
            end
            m_ctrl = bus_wdata_i & 16'hFFED;
          end
          4'h2: m_cfg = bus_wdata_i[3:0];
          4'h4: m_trmp = bus_wdata_i[9:0];
          4'h6: m_trmn = bus_wdata_i[9:0];
          4'h8: clr = 1;
          default: ;
        endcase
      end
      if (set_int) m_int = 1; else if (clr) m_int = 0;
    end
  end

  function automatic logic [15:0] mread(logic [3:0] a);
    case (a)
      4'h0: return m_ctrl | (16'(m_busy) << 1) | (16'(m_int) << 4);
      4'h2: return {12'h0, m_cfg};
      4'h4: return {6'h0, m_trmp};
      4'h6: return {6'h0, m_trmn};
      4'hA: return {6'h0, m_res};
      default: return 16'h0;
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic esign;
      logic [3:0] emux;
      #1;
      esign = m_ctrl[10] ^ (m_stage == 2);
      emux  = m_ctrl[11] ? m_ctrl[9:6] : {3'b0, |m_ctrl[9:6]};
      chk(bus_rdata_o == mread(bus_addr_i), "R1 readback", bus_rdata_o, mread(bus_addr_i));
      chk(irq_o == (m_int & m_ctrl[5]), "R6 irq", irq_o, m_int & m_ctrl[5]);
      chk(cnv_start_o == (m_busy && m_req), "R3 start pulse", cnv_start_o, m_busy && m_req);
      chk(cnv_en_o == m_ctrl[0], "R7 enable", cnv_en_o, m_ctrl[0]);
      chk(cnv_sign_o == esign, "R10 sign", cnv_sign_o, esign);
      chk(mux_sel_o == emux, "R9 mux", mux_sel_o, emux);
      chk(offset_trim_o == ((m_ctrl[11] && esign) ? m_trmn : m_trmp), "R10 trim",
          offset_trim_o, (m_ctrl[11] && esign) ? m_trmn : m_trmp);
      chk({ldo_zero_o, ldo_en_o, mute_o, single_ended_o, clk_sel_o} ==
          {m_ctrl[15], m_ctrl[14], m_ctrl[12], m_ctrl[11], m_ctrl[3]}, "R2 pins",
          {ldo_zero_o, ldo_en_o, mute_o, single_ended_o, clk_sel_o},
          {m_ctrl[15], m_ctrl[14], m_ctrl[12], m_ctrl[11], m_ctrl[3]});
      chk(ana_cfg_o == m_cfg, "R2 cfg", ana_cfg_o, m_cfg);
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string req);
    @(negedge clk_i);
    bus_addr_i = a;
    #1;
    chk(bus_rdata_o == exp, req, bus_rdata_o, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_busy && n < 200) begin @(negedge clk_i); n++; end
    repeat (2) @(negedge clk_i);
  endtask

  // ctrl field helpers: en=0, start=1, mask=5, sel=9:6, sign=10, se=11, chop=13
  function automatic logic [15:0] cw(bit st, bit mask, logic [3:0] sel, bit sign, bit se, bit chop);
    return 16'h1 | (16'(st) << 1) | (16'(mask) << 5) | (16'(sel) << 6) |
           (16'(sign) << 10) | (16'(se) << 11) | (16'(chop) << 13);
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset values
    for (int a = 0; a < 16; a += 2) rd(4'(a), 16'h0, "R1 reset");
    chk(irq_o == 0, "R6 reset irq", irq_o, 0);
    // R1 widths and unmapped offsets
    wr(4'h4, 16'hFFFF); rd(4'h4, 16'h03FF, "R1 trim+ width");
    wr(4'h6, 16'h0155); rd(4'h6, 16'h0155, "R1 trim-");
    wr(4'h2, 16'hFFFA); rd(4'h2, 16'h000A, "R2 cfg width");
    wr(4'hC, 16'h1234); rd(4'hC, 16'h0, "R1 0xC ignored");
    wr(4'hE, 16'h5678); rd(4'hE, 16'h0, "R1 0xE ignored");
    // R2 test/clk_sel/mute/ldo bits stored, no start
    wr(4'h0, 16'hD00C); rd(4'h0, 16'hD00C, "R2 ctrl fields");
    chk(ldo_en_o && ldo_zero_o && mute_o && clk_sel_o, "R2 pins", 0, 1);
    // R7 start with enable clear ignored
    p0 = pulses;
    wr(4'h0, 16'h0002); repeat (3) @(negedge clk_i);
    chk(pulses == p0, "R7 start without enable", pulses - p0, 0);
    rd(4'h0, 16'h0000, "R7 start bit stays 0");
    // R3 R4 single-ended, sign 0
    samp_q.push_back(10'h2A5);
    wr(4'h0, cw(1, 1, 4'd5, 0, 1, 0));
    rd(4'h0, cw(1, 1, 4'd5, 0, 1, 0), "R3 busy reads 1");
    wait_idle();
    rd(4'hA, 16'h02A5, "R4 result");
    rd(4'h0, cw(0, 1, 4'd5, 0, 1, 0) | 16'h10, "R4 start clear int set");
    chk(irq_o == 1, "R6 irq unmasked", irq_o, 1);
    // R5 clear by any value
    wr(4'h8, 16'hBEEF); rd(4'h8, 16'h0, "R5 clear reads 0");
    chk(irq_o == 0, "R5 cleared", irq_o, 0);
    // R6 masked
    samp_q.push_back(10'h3FF);
    wr(4'h0, cw(1, 0, 4'd9, 1, 1, 0));
    wait_idle();
    rd(4'h0, cw(0, 0, 4'd9, 1, 1, 0) | 16'h10, "R6 status set");
    chk(irq_o == 0, "R6 masked irq", irq_o, 0);
    chk(offset_trim_o == 10'h155, "R10 negative trim", offset_trim_o, 10'h155);
    wr(4'h8, 16'h0);
    // R9 differential
    wr(4'h0, cw(0, 1, 4'd7, 1, 0, 0)); @(negedge clk_i);
    chk(mux_sel_o == 4'd1, "R9 diff pair 2/3", mux_sel_o, 1);
    chk(offset_trim_o == 10'h3FF, "R10 diff uses positive", offset_trim_o, 10'h3FF);
    wr(4'h0, cw(0, 1, 4'd0, 0, 0, 0)); @(negedge clk_i);
    chk(mux_sel_o == 4'd0, "R9 diff pair 0/1", mux_sel_o, 0);
    // R8 start while busy ignored
    p0 = pulses;
    samp_q.push_back(10'h111); samp_q.push_back(10'h222);
    wr(4'h0, cw(1, 1, 4'd2, 0, 1, 0));
    wr(4'h0, cw(1, 1, 4'd2, 0, 1, 0));
    wait_idle();
    chk(pulses - p0 == 1, "R8 single request", pulses - p0, 1);
    rd(4'hA, 16'h0111, "R8 result of first");
    samp_q.delete();
    // R5 clear on completion edge: set wins
    samp_q.push_back(10'h0AA);
    wr(4'h0, cw(1, 1, 4'd1, 0, 1, 0));
    do @(negedge clk_i); while (!cnv_done_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = 4'h8; bus_wdata_i = 16'h1;
    @(negedge clk_i); bus_sel_i = 0; bus_we_i = 0;
    rd(4'h0, cw(0, 1, 4'd1, 0, 1, 0) | 16'h10, "R5 set wins over clear");
    wr(4'h8, 16'h0);
    // R7 abort
    samp_q.push_back(10'h3C3);
    wr(4'h0, cw(1, 1, 4'd3, 0, 1, 0));
    @(negedge clk_i);
    wr(4'h0, 16'h0000);
    repeat (lat + 4) @(negedge clk_i);
    rd(4'h0, 16'h0000, "R7 aborted, no int");
    rd(4'hA, 16'h00AA, "R7 result unchanged");
    chk(irq_o == 0, "R7 no irq", irq_o, 0);
    samp_q.delete();
    // R11 chop: a=0x300, b=0x0FF -> mean 0x300
    p0 = pulses;
    samp_q.push_back(10'h300); samp_q.push_back(10'h0FF);
    wr(4'h0, cw(1, 1, 4'd4, 0, 1, 1));
    wait_idle();
    chk(pulses - p0 == 2, "R11 two requests", pulses - p0, 2);
    rd(4'hA, 16'h0300, "R11 chop mean");
    wr(4'h8, 16'h0);
    // R11 rounding: a=0x101, ~b=0x102 -> 0x102
    samp_q.push_back(10'h101); samp_q.push_back(~10'h102);
    wr(4'h0, cw(1, 1, 4'd4, 1, 1, 1));
    wait_idle();
    rd(4'hA, 16'h0102, "R11 chop rounding");
    chk(irq_o == 1, "R11 irq after second", irq_o, 1);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule